// File: doc/BRIEF.md
# Calibration and Fast-Lock Sequencer

This block controls the timing of a frequency synthesizer's lock-up after a new frequency is programmed. An update strobe starts it. It then counts clock enables that run at the phase-detector rate and steps through three timed phases. First comes a VCO calibration window. During this window the charge pump is held in high impedance and the VCO tune node is tied to an internal reference. Next comes an optional fast-lock window, in which an alternate charge-pump current code is selected. Last comes normal operation, which uses the normal current code.

The calibration window is (6 + 2^T) × 8 + 3 enables long, where T is the calibration-time field. T is clamped to the range 1..11, and an out-of-range value raises an error flag. The fast-lock window is 511 + 512 × F enables long, where F is the four-bit length field. A strobe received at any time abandons the running sequence and starts again from calibration. The settings are captured at the strobe. The two current codes and the forced tri-state input are used live. The analog calibration search and the charge pump itself lie outside this block.

The states are IDLE (after reset, before any strobe), CAL, FAST and NORM. The transitions are:
- any state to CAL on a strobe;
- CAL to FAST on the last calibration enable when fast lock is enabled;
- CAL to NORM on that enable when fast lock is disabled;
- FAST to NORM on the last fast-lock enable.

Top module: `lockup_sequencer`

## Requirements
- R1: CAL lasts exactly (6 + 2^T) × 8 + 3 cycles in which `pfd_tick` is high, counted from the cycle after the strobe. `phase` changes only on a strobe or on a cycle in which `pfd_tick` is high. `phase` encoding: 0 = IDLE, 1 = CAL, 2 = FAST, 3 = NORM.
- R2: A `cal_time` of 0 is used as 1, and a value of 12..15 is used as 11. `caltm_err` is updated at each strobe: it is 1 if the captured value was out of range and 0 otherwise. It holds that value until the next strobe.
- R3: While in CAL, `cp_tristate`, `tune_to_ref` and `busy` are all 1.
- R4: With `fl_en` = 1 at the strobe, CAL is followed by FAST, which lasts 511 + 512 × F enable cycles (F = `fl_len` captured at the strobe). FAST is entered only from CAL.
- R5: In FAST, `cp_code` equals `cp_boost`. In every other phase, `cp_code` equals `cp_norm`. Both codes are followed live.
- R6: With `fl_en` = 0 at the strobe, CAL goes directly to NORM, and no FAST cycle occurs.
- R7: While `force_hiz` = 1, `cp_tristate` is 1 in every phase. Outside CAL, `cp_tristate` equals `force_hiz`.
- R8: A strobe in any phase, including mid-CAL and mid-FAST, puts the block in CAL on the next cycle with a fresh full calibration count.
- R9: `busy` is 1 exactly in CAL and FAST. `done` is a one-cycle pulse in the first cycle of NORM, and appears at no other time.
- R10: After reset the block is in IDLE with `busy`, `done`, `tune_to_ref` and `caltm_err` all at 0. `cp_code` equals `cp_norm`, and `cp_tristate` equals `force_hiz`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_tick | input | 1 | Phase-detector-rate clock enable |
| upd_stb | input | 1 | Frequency-update strobe, starts or restarts the sequence |
| cal_time | input | 4 | Calibration time exponent T |
| fl_en | input | 1 | Fast-lock enable |
| fl_len | input | 4 | Fast-lock length field F |
| cp_norm | input | 3 | Normal charge-pump current code |
| cp_boost | input | 3 | Fast-lock charge-pump current code |
| force_hiz | input | 1 | Force charge-pump tri-state |
| phase | output | 2 | Current phase (0 IDLE, 1 CAL, 2 FAST, 3 NORM) |
| cp_tristate | output | 1 | Charge-pump output high impedance |
| tune_to_ref | output | 1 | VCO tune node disconnected from the loop filter and tied to the reference |
| cp_code | output | 3 | Selected charge-pump current code |
| busy | output | 1 | Calibration or fast lock in progress |
| done | output | 1 | One-cycle pulse on entry to normal operation |
| caltm_err | output | 1 | Captured calibration time was out of range |

## Verification
The properties assume that `upd_stb` and `pfd_tick` are synchronous single-bit controls. They also assume that `fl_en`, `fl_len` and `cal_time` matter only at the strobe, so any change between strobes is harmless.

The stimulus changes every input only on the falling clock edge. It drives `pfd_tick` on every other cycle, so enable-free cycles can be seen to leave the phase unchanged. Strobes last a single cycle. They are placed in IDLE, in NORM, mid-CAL and mid-FAST. The calibration field is swept across legal values and both prohibited ranges, so the clamp and the error flag are reached only through the port.

// File: rtl/lockup_pkg.sv
package lockup_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CAL  = 2'd1,
        PH_FAST = 2'd2,
        PH_NORM = 2'd3
    } phase_t;

endpackage

// File: rtl/lockup_len_calc.sv
module lockup_len_calc #(
    parameter int CALTM_W   = 4,
    parameter int FAST_W    = 4,
    parameter int CNT_W     = 15,
    parameter int CALTM_MIN = 1,
    parameter int CALTM_MAX = 11,
    parameter int CAL_OFS   = 6,
    parameter int CAL_SH    = 3,
    parameter int CAL_TAIL  = 3,
    parameter int FL_BASE   = 511,
    parameter int FL_SH     = 9
) (
    input  logic [CALTM_W-1:0] caltm,
    input  logic [FAST_W-1:0]  fast,
    output logic [CNT_W-1:0]   cal_len,
    output logic [CNT_W-1:0]   fast_len,
    output logic               caltm_bad
);

    localparam logic [CALTM_W-1:0] C_LO = CALTM_W'(CALTM_MIN);
    localparam logic [CALTM_W-1:0] C_HI = CALTM_W'(CALTM_MAX);

    logic [CALTM_W-1:0] c_eff;

    always_comb begin
        caltm_bad = (caltm < C_LO) || (caltm > C_HI);
        if (caltm < C_LO) begin
            c_eff = C_LO;
        end else if (caltm > C_HI) begin
            c_eff = C_HI;
        end else begin
            c_eff = caltm;
        end
        cal_len  = ((CNT_W'(CAL_OFS) + (CNT_W'(1) << c_eff)) << CAL_SH) + CNT_W'(CAL_TAIL);
        fast_len = CNT_W'(FL_BASE) + (CNT_W'(fast) << FL_SH);
    end

endmodule

// File: rtl/lockup_timer.sv
module lockup_timer #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    assign last = tick && (cnt == CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/lockup_sequencer.sv
module lockup_sequencer
    import lockup_pkg::*;
#(
    parameter int CALTM_W   = 4,
    parameter int FAST_W    = 4,
    parameter int CP_W      = 3,
    parameter int CALTM_MIN = 1,
    parameter int CALTM_MAX = 11,
    parameter int CAL_OFS   = 6,
    parameter int CAL_SH    = 3,
    parameter int CAL_TAIL  = 3,
    parameter int FL_BASE   = 511,
    parameter int FL_SH     = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pfd_tick,
    input  logic               upd_stb,
    input  logic [CALTM_W-1:0] cal_time,
    input  logic               fl_en,
    input  logic [FAST_W-1:0]  fl_len,
    input  logic [CP_W-1:0]    cp_norm,
    input  logic [CP_W-1:0]    cp_boost,
    input  logic               force_hiz,
    output logic [1:0]         phase,
    output logic               cp_tristate,
    output logic               tune_to_ref,
    output logic [CP_W-1:0]    cp_code,
    output logic               busy,
    output logic               done,
    output logic               caltm_err
);

    localparam int CAL_MAX_LEN  = ((CAL_OFS + (1 << CALTM_MAX)) << CAL_SH) + CAL_TAIL;
    localparam int FAST_MAX_LEN = FL_BASE + (((1 << FAST_W) - 1) << FL_SH);
    localparam int MAX_LEN      = (CAL_MAX_LEN > FAST_MAX_LEN) ? CAL_MAX_LEN : FAST_MAX_LEN;
    localparam int CNT_W        = $clog2(MAX_LEN + 1);

    phase_t              state, state_d;
    logic                fl_en_q;
    logic [FAST_W-1:0]   fl_len_q;
    logic                err_q;
    logic                done_q;
    logic [CNT_W-1:0]    cal_len, fast_len, load_val;
    logic                caltm_bad, last, load, enter_norm;

    lockup_len_calc #(
        .CALTM_W(CALTM_W), .FAST_W(FAST_W), .CNT_W(CNT_W),
        .CALTM_MIN(CALTM_MIN), .CALTM_MAX(CALTM_MAX),
        .CAL_OFS(CAL_OFS), .CAL_SH(CAL_SH), .CAL_TAIL(CAL_TAIL),
        .FL_BASE(FL_BASE), .FL_SH(FL_SH)
    ) u_len (
        .caltm    (cal_time),
        .fast     (fl_len_q),
        .cal_len  (cal_len),
        .fast_len (fast_len),
        .caltm_bad(caltm_bad)
    );

    // Reload on a strobe (calibration) or on the CAL-to-FAST hand-over.
    assign load     = upd_stb || ((state == PH_CAL) && last && fl_en_q);
    assign load_val = upd_stb ? cal_len : fast_len;

    lockup_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .tick    (pfd_tick),
        .last    (last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state;
        if (upd_stb) begin
            state_d = PH_CAL;
        end else begin
            unique case (state)
                PH_IDLE: state_d = PH_IDLE;
                PH_CAL:  if (last) state_d = fl_en_q ? PH_FAST : PH_NORM;
                PH_FAST: if (last) state_d = PH_NORM;
                PH_NORM: state_d = PH_NORM;
            endcase
        end
    end

    assign enter_norm = (state_d == PH_NORM) && (state != PH_NORM);

    // State register and captured settings.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PH_IDLE;
            fl_en_q  <= 1'b0;
            fl_len_q <= '0;
            err_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            state  <= state_d;
            done_q <= enter_norm;
            if (upd_stb) begin
                fl_en_q  <= fl_en;
                fl_len_q <= fl_len;
                err_q    <= caltm_bad;
            end
        end
    end

    // Output decode.
    always_comb begin
        phase       = state;
        done        = done_q;
        caltm_err   = err_q;
        cp_code     = cp_norm;
        cp_tristate = force_hiz;
        tune_to_ref = 1'b0;
        busy        = 1'b0;
        unique case (state)
            PH_IDLE: ;
            PH_CAL: begin
                cp_tristate = 1'b1;
                tune_to_ref = 1'b1;
                busy        = 1'b1;
            end
            PH_FAST: begin
                cp_code = cp_boost;
                busy    = 1'b1;
            end
            PH_NORM: ;
        endcase
    end

endmodule

// File: rtl/lockup_seq_chk.sv
module lockup_seq_chk
    import lockup_pkg::*;
#(
    parameter int CP_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pfd_tick,
    input logic            upd_stb,
    input logic [1:0]      phase,
    input logic            cp_tristate,
    input logic            tune_to_ref,
    input logic            force_hiz,
    input logic [CP_W-1:0] cp_code,
    input logic [CP_W-1:0] cp_norm,
    input logic            busy,
    input logic            done,
    input logic            caltm_err
);

    a_r1_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!pfd_tick && !upd_stb) |=> $stable(phase));

    a_r2_err_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_stb |=> $stable(caltm_err));

    a_r3_cal_isolates: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CAL) |-> (cp_tristate && tune_to_ref && busy));

    a_r4_fast_after_cal: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_FAST) && ($past(phase) != PH_FAST)) |-> ($past(phase) == PH_CAL));

    a_r5_norm_code: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FAST) |-> (cp_code == cp_norm));

    a_r7_hiz_forced: assert property (@(posedge clk) disable iff (!rst_n)
        force_hiz |-> cp_tristate);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        upd_stb |=> (phase == PH_CAL));

    a_r9_done_in_norm: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((phase == PH_NORM) && !busy));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind lockup_sequencer lockup_seq_chk #(.CP_W(CP_W)) u_chk (.*);

// File: tb/test_lockup_sequencer.sv
module test_lockup_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int WAIT_LIMIT = 60000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pfd_tick = 1'b0;
    logic       upd_stb = 1'b0;
    logic [3:0] cal_time = 4'd1;
    logic       fl_en = 1'b0;
    logic [3:0] fl_len = 4'd0;
    logic [2:0] cp_norm = 3'd2;
    logic [2:0] cp_boost = 3'd6;
    logic       force_hiz = 1'b0;
    logic [1:0] phase;
    logic       cp_tristate, tune_to_ref, busy, done, caltm_err;
    logic [2:0] cp_code;

    lockup_sequencer i_lockup_sequencer (
        .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .upd_stb(upd_stb),
        .cal_time(cal_time), .fl_en(fl_en), .fl_len(fl_len),
        .cp_norm(cp_norm), .cp_boost(cp_boost), .force_hiz(force_hiz),
        .phase(phase), .cp_tristate(cp_tristate), .tune_to_ref(tune_to_ref),
        .cp_code(cp_code), .busy(busy), .done(done), .caltm_err(caltm_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        int cal_ticks;
        int fast_ticks;
        bit err;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    int   cal_cnt = 0, fast_cnt = 0;
    bit   cal_bad = 0, fast_bad = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic int exp_cal(input int c);
        int cc;
        cc = (c < 1) ? 1 : ((c > 11) ? 11 : c);
        return (6 + (1 << cc)) * 8 + 3;
    endfunction

    // Clock enable on every other cycle.
    initial begin
        forever begin
            @(negedge clk);
            pfd_tick = ~pfd_tick;
        end
    end

    // Driver: start a sequence and optionally queue its expectation.
    task automatic run_seq(input int c, input bit fe, input int f, input bit push, input bit wait_done);
        exp_t e;
        @(negedge clk);
        cal_time = 4'(c);
        fl_en    = fe;
        fl_len   = 4'(f);
        upd_stb  = 1'b1;
        if (push) begin
            e.cal_ticks  = exp_cal(c);
            e.fast_ticks = fe ? (511 + 512 * f) : 0;
            e.err        = (c < 1) || (c > 11);
            sb.push_back(e);
        end
        @(negedge clk);
        upd_stb = 1'b0;
        check(phase == 2'd1, "R8 phase after strobe", int'(phase), 1);
        if (wait_done) begin
            for (int i = 0; i < WAIT_LIMIT && !done; i++) @(negedge clk);
            check(done == 1'b1, "R9 done reached", int'(done), 1);
        end
    endtask

    // Monitor: measure each sequence and compare with the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD * 3 / 4);
            if (rst_n) begin
                if (done) begin
                    if (sb.size() == 0) begin
                        check(0, "R9 unexpected done", 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(cal_cnt == e.cal_ticks, "R1 calibration length", cal_cnt, e.cal_ticks);
                        check(fast_cnt == e.fast_ticks, "R4/R6 fast-lock length", fast_cnt, e.fast_ticks);
                        check(caltm_err == e.err, "R2 error flag", int'(caltm_err), int'(e.err));
                        check(!cal_bad, "R3 calibration outputs", int'(cal_bad), 0);
                        check(!fast_bad, "R5 fast-lock outputs", int'(fast_bad), 0);
                        check(!busy, "R9 busy clear in normal", int'(busy), 0);
                    end
                end
                if (upd_stb) begin
                    cal_cnt  = 0;
                    fast_cnt = 0;
                    cal_bad  = 0;
                    fast_bad = 0;
                end else if (phase == 2'd1) begin
                    if (pfd_tick) cal_cnt++;
                    if (!(cp_tristate && tune_to_ref && busy)) cal_bad = 1;
                end else if (phase == 2'd2) begin
                    if (pfd_tick) fast_cnt++;
                    if (cp_code != cp_boost || !busy || cp_tristate != force_hiz || tune_to_ref)
                        fast_bad = 1;
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        check(0, "R9 watchdog expired", 0, 1);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(phase == 2'd0, "R10 phase", int'(phase), 0);
        check(!busy && !done && !tune_to_ref && !caltm_err, "R10 flags",
              int'({busy, done, tune_to_ref, caltm_err}), 0);
        check(cp_code == cp_norm, "R10 cp_code", int'(cp_code), int'(cp_norm));
        check(cp_tristate == 1'b0, "R10 tristate", int'(cp_tristate), 0);
        // R7 in idle
        force_hiz = 1'b1;
        @(negedge clk);
        check(cp_tristate == 1'b1, "R7 idle forced hiz", int'(cp_tristate), 1);
        force_hiz = 1'b0;

        // R6: no fast lock
        run_seq(1, 1'b0, 0, 1'b1, 1'b1);
        @(negedge clk);
        check(phase == 2'd3, "R6 normal phase", int'(phase), 3);
        cp_norm = 3'd5;
        @(negedge clk);
        check(cp_code == 3'd5, "R5 live normal code", int'(cp_code), 5);
        check(cp_tristate == 1'b0 && tune_to_ref == 1'b0, "R7 normal tristate follows input",
              int'({cp_tristate, tune_to_ref}), 0);

        // R4 fast lock with shortest window
        run_seq(3, 1'b1, 0, 1'b1, 1'b1);
        // R2 low clamp
        run_seq(0, 1'b1, 2, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        check(caltm_err == 1'b1, "R2 error held", int'(caltm_err), 1);
        // R1 largest legal value
        run_seq(11, 1'b0, 0, 1'b1, 1'b1);
        check(caltm_err == 1'b0, "R2 error cleared", int'(caltm_err), 0);
        // R2 high clamp, R4 longest window, R7 forced hiz throughout
        force_hiz = 1'b1;
        cp_boost  = 3'd7;
        run_seq(14, 1'b1, 15, 1'b1, 1'b1);
        @(negedge clk);
        check(cp_tristate == 1'b1, "R7 normal forced hiz", int'(cp_tristate), 1);
        force_hiz = 1'b0;

        // R8 abort mid calibration
        run_seq(5, 1'b1, 3, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        check(phase == 2'd1, "R8 still calibrating", int'(phase), 1);
        run_seq(2, 1'b0, 0, 1'b1, 1'b1);

        // R8 abort mid fast lock
        run_seq(1, 1'b1, 1, 1'b0, 1'b0);
        for (int i = 0; i < WAIT_LIMIT && phase != 2'd2; i++) @(negedge clk);
        repeat (50) @(negedge clk);
        check(phase == 2'd2, "R8 in fast lock before abort", int'(phase), 2);
        check(cp_code == cp_boost, "R5 fast code", int'(cp_code), int'(cp_boost));
        run_seq(1, 1'b0, 0, 1'b1, 1'b1);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R9 all sequences completed", sb.size(), 0);
        finish_up();
    end

endmodule